// File: doc/BRIEF.md
# Timer Tick Interrupt Pending Tracker

This block sits between a channel-0 interval timer and the interrupt controller. Every time the timer expires, the tracker records an undelivered tick. It raises a one-cycle interrupt request whenever at least one tick is owed and the previous request has been acknowledged. A reinject control selects between two policies. With reinject on, every missed tick is delivered later, one request per acknowledge. With reinject off, ticks that pile up are merged into a single outstanding tick.

The channel's counting mode decides whether an expiry counts at all. Single-shot modes honour only the first expiry after a count reload. Repeating modes honour every expiry. All other modes ignore expiries. A count reload, an unmask event and reset each discard the owed ticks and re-open the acknowledge gate. This lets the next tick raise a request at once.

Top module: `tick_irq_tracker`

## Requirements
- R1: After reset, `pend_flag` and `irq_req` are low and the acknowledge gate is open, so the first honoured expiry raises a request without any prior acknowledge.
- R2: With `reinject_en` high, N honoured expiries followed by N acknowledges produce exactly N request pulses. `pend_flag` then falls.
- R3: With `reinject_en` low, an honoured expiry leaves the owed-tick count at no more than one.
- R4: An acknowledge while no tick is owed leaves the count at zero (`pend_flag` stays low) and opens the acknowledge gate.
- R5: A request is raised only when the owed-tick count is nonzero and the gate is open. Raising it closes the gate, so no second request appears before an acknowledge.
- R6: `irq_req` is high for exactly one cycle, then low.
- R7: In single-shot modes (`mode` = 1 or 4), only the first expiry after a reload is honoured.
- R8: In modes 0, 5, 6 and 7, expiries are ignored. In repeating modes (`mode` = 2 or 3), every expiry is honoured.
- R9: A `reload` pulse clears the owed-tick count, opens the gate and re-arms single-shot modes.
- R10: An `unmask` pulse clears the owed-tick count and opens the gate, but does not re-arm single-shot modes.
- R11: The owed-tick count is 8 bits wide and saturates at 255 instead of wrapping.
- R12: An honoured expiry and an acknowledge in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire | input | 1 | Channel-0 expiry pulse, one per tick |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| unmask | input | 1 | Interrupt line unmasked event |
| reload | input | 1 | Channel-0 count reload event |
| reinject_en | input | 1 | 1: deliver every missed tick; 0: merge missed ticks |
| mode | input | 3 | Channel-0 counting mode |
| irq_req | output | 1 | Interrupt request, one-cycle pulse |
| pend_flag | output | 1 | High while any tick is owed |

## Verification
The hardest state to reach is the saturated count. Reaching it takes more than 255 expiries with no acknowledge in between. The stimulus therefore holds `expire` high for 300 cycles in a repeating mode. It then acknowledges one request at a time and counts the pulses until `pend_flag` drops: 255 pulses are expected. A wrapping counter would give a much smaller total.

The second hard case is an expiry and an acknowledge landing in the same cycle. This is set up while two ticks are owed and a request is outstanding. The total number of pulses that follow then shows whether the count stayed unchanged.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int MODE_W = 3;

  function automatic logic mode_single(input logic [MODE_W-1:0] m);
    return (m == 3'd1) || (m == 3'd4);
  endfunction

  function automatic logic mode_repeat(input logic [MODE_W-1:0] m);
    return (m == 3'd2) || (m == 3'd3);
  endfunction
endpackage

// File: rtl/tick_gate.sv
module tick_gate
  import tick_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              reload,
  input  logic [MODE_W-1:0] mode,
  output logic              tick_ok
);
  logic armed_q, armed_d, armed_en;

  always_comb begin
    tick_ok  = expire && (mode_repeat(mode) || (mode_single(mode) && armed_q));
    armed_d  = armed_q;
    armed_en = 1'b0;
    if (reload) begin
      armed_d  = 1'b1;
      armed_en = 1'b1;
    end else if (tick_ok && mode_single(mode)) begin
      armed_d  = 1'b0;
      armed_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (armed_en) armed_q <= armed_d;
  end
endmodule

// File: rtl/pend_counter.sv
module pend_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ack,
  input  logic             clear,
  input  logic             reinject_en,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, dec;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = clear || tick || ack;
    dec    = ack && (cnt_q != '0);
    if (clear) begin
      cnt_d = '0;
    end else begin
      if (tick && !dec)      cnt_d = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
      else if (!tick && dec) cnt_d = cnt_q - CNT_ONE;
      if (tick && !reinject_en && (cnt_d > CNT_ONE)) cnt_d = CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/irq_issuer.sv
module irq_issuer (
  input  logic clk,
  input  logic rst_n,
  input  logic owed,
  input  logic ack,
  input  logic clear,
  output logic gate_open,
  output logic irq
);
  logic open_q, open_d, irq_q, issue;

  always_comb begin
    issue  = open_q && owed && !clear;
    open_d = open_q;
    if (clear)      open_d = 1'b1;
    else if (issue) open_d = 1'b0;
    else if (ack)   open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      irq_q  <= issue;
    end
  end

  assign gate_open = open_q;
  assign irq       = irq_q;
endmodule

// File: rtl/tick_irq_tracker.sv
module tick_irq_tracker
  import tick_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              irq_ack,
  input  logic              unmask,
  input  logic              reload,
  input  logic              reinject_en,
  input  logic [MODE_W-1:0] mode,
  output logic              irq_req,
  output logic              pend_flag
);
  logic             rst_s1, rst_sn;
  logic             tick_ok, clear, gate_open;
  logic [CNT_W-1:0] pend_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign clear = reload || unmask;

  tick_gate u_gate (
    .clk(clk), .rst_n(rst_sn), .expire(expire), .reload(reload),
    .mode(mode), .tick_ok(tick_ok)
  );

  pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .tick(tick_ok), .ack(irq_ack),
    .clear(clear), .reinject_en(reinject_en), .cnt(pend_cnt)
  );

  irq_issuer u_iss (
    .clk(clk), .rst_n(rst_sn), .owed(pend_cnt != '0), .ack(irq_ack),
    .clear(clear), .gate_open(gate_open), .irq(irq_req)
  );

  assign pend_flag = (pend_cnt != '0);
endmodule

// File: rtl/tick_irq_tracker_chk.sv
module tick_irq_tracker_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             expire,
  input logic             irq_ack,
  input logic             unmask,
  input logic             reload,
  input logic             reinject_en,
  input logic [2:0]       mode,
  input logic             irq_req,
  input logic             pend_flag,
  input logic             tick_ok,
  input logic             gate_open,
  input logic [CNT_W-1:0] pend_cnt
);
  AST_REQ_NEEDS_OWED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> $past(pend_flag) && $past(gate_open)); // R5
  AST_GATE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !gate_open); // R5
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req); // R6
  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !pend_flag && gate_open); // R9
  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    unmask |=> !pend_flag && gate_open); // R10
  AST_MERGE_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reinject_en && tick_ok) |=> (pend_cnt <= 1)); // R3
  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (mode == 3'd0 || mode > 3'd4)) |-> !tick_ok); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == {CNT_W{1'b1}} && !irq_ack && !reload && !unmask) |=> pend_cnt == {CNT_W{1'b1}}); // R11
endmodule

bind tick_irq_tracker tick_irq_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .expire(expire), .irq_ack(irq_ack),
  .unmask(unmask), .reload(reload), .reinject_en(reinject_en), .mode(mode),
  .irq_req(irq_req), .pend_flag(pend_flag), .tick_ok(tick_ok),
  .gate_open(gate_open), .pend_cnt(pend_cnt)
);

// File: tb/sim_tick_irq_tracker.sv
`timescale 1ns/1ps
module sim_tick_irq_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic expire = 1'b0, irq_ack = 1'b0, unmask = 1'b0, reload = 1'b0;
  logic reinject_en = 1'b1;
  logic [2:0] mode = 3'd2;
  logic irq_req, pend_flag;

  int checks = 0, errors = 0;
  int pulses = 0, wide = 0;
  int exp_p = 0;
  logic prev_irq = 1'b0;

  typedef struct { int p; bit f; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  tick_irq_tracker u0 (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_ack(irq_ack),
    .unmask(unmask), .reload(reload), .reinject_en(reinject_en), .mode(mode),
    .irq_req(irq_req), .pend_flag(pend_flag)
  );

  // monitor: counts pulses, pops expectations and compares
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (irq_req === 1'b1) pulses++;
      if (prev_irq && irq_req) wide++;
      prev_irq = irq_req;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (pulses != it.p || pend_flag !== it.f) begin
          errors++;
          $display("FAIL %s: pulses=%0d pend=%b expected pulses=%0d pend=%b",
                   it.tag, pulses, pend_flag, it.p, it.f);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    expire = 1'b1; cyc(1); expire = 1'b0; cyc(3);
  endtask

  task automatic ack();
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0; cyc(3);
  endtask

  task automatic do_reload();
    reload = 1'b1; cyc(1); reload = 1'b0; cyc(3);
  endtask

  task automatic expect_st(input int add, input bit f, input string tag);
    item_t it;
    exp_p += add;
    it.p = exp_p; it.f = f; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(4);
    expect_st(0, 0, "R1 reset state");

    // R2 / R5: three ticks, one request until acknowledged
    tick(); tick(); tick();
    expect_st(1, 1, "R5 single request before ack");
    ack(); expect_st(1, 1, "R2 second delivery");
    ack(); expect_st(1, 1, "R2 third delivery");
    ack(); expect_st(0, 0, "R2 all delivered");

    // R4: spurious ack keeps zero, gate stays open
    ack(); expect_st(0, 0, "R4 spurious ack no underflow");
    tick(); expect_st(1, 1, "R4 gate open after spurious ack");
    ack(); expect_st(0, 0, "R4 drained");

    // R3: merge without reinject
    reinject_en = 1'b0;
    tick(); tick(); tick();
    expect_st(1, 1, "R3 first merged request");
    ack(); expect_st(0, 0, "R3 merged ticks gone after one ack");
    reinject_en = 1'b1;

    // R8: idle modes ignore expiries
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m > 4) begin
        mode = 3'(m);
        tick();
      end
    end
    expect_st(0, 0, "R8 idle modes ignore expiry");

    // R7: single-shot
    mode = 3'd1; do_reload();
    tick(); expect_st(1, 1, "R7 first single-shot expiry");
    ack(); tick(); expect_st(0, 0, "R7 second expiry ignored");
    do_reload(); tick(); expect_st(1, 1, "R7 rearmed by reload");
    ack();

    // R10: unmask clears but does not rearm
    mode = 3'd4; do_reload();
    tick(); expect_st(1, 1, "R10 mode4 expiry");
    unmask = 1'b1; cyc(1); unmask = 1'b0; cyc(3);
    expect_st(0, 0, "R10 unmask clears owed");
    tick(); expect_st(0, 0, "R10 unmask does not rearm");
    mode = 3'd3;
    tick(); expect_st(1, 1, "R10 gate open after unmask, R8 mode3");

    // R9: reload clears outstanding and opens gate
    do_reload(); expect_st(0, 0, "R9 reload clears");
    mode = 3'd2;
    tick(); expect_st(1, 1, "R9 request without ack after reload");
    ack();

    // R12: expiry and ack together
    tick(); tick();
    expect_st(1, 1, "R12 setup two owed");
    expire = 1'b1; irq_ack = 1'b1; cyc(1); expire = 1'b0; irq_ack = 1'b0; cyc(3);
    expect_st(1, 1, "R12 simultaneous keeps count");
    ack(); expect_st(1, 1, "R12 last owed delivered");
    ack(); expect_st(0, 0, "R12 drained");

    // R11: saturation at 255
    expire = 1'b1; cyc(300); expire = 1'b0; cyc(3);
    expect_st(1, 1, "R11 burst first request");
    for (int i = 0; i < 254; i++) ack();
    expect_st(254, 1, "R11 254 redeliveries");
    ack(); expect_st(0, 0, "R11 saturated count drained");

    checks++;
    if (wide != 0) begin
      errors++;
      $display("FAIL R6 pulse width: wide=%0d expected=0", wide);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule